// File: doc/BRIEF.md
# Digital Phase-Locked Loop with Selectable Phase Detector

This block is an all-digital phase-locked loop. It runs entirely on the system clock. A reference input is synchronised and compared against a feedback square wave. The feedback wave comes from a phase-accumulator oscillator through a programmable divider. A select input picks one of two detectors, and both always see the same reference and the same feedback:

- an exclusive-OR detector, which idles at the centre of the frequency window;
- a rising-edge phase/frequency detector, which drives to zero phase error and idles at the bottom of the window.

The detector error drives a proportional-plus-integral loop filter. The integral word sets the oscillator increment and is brought out as the demodulated control word. A programmable increment window bounds that word. Because the loop divides the oscillator by N before comparison, it can synthesise N times the reference frequency.

An inhibit input freezes the oscillator, the divider and the filter, which gives on/off keying. An indicator shows when neither edge of the edge detector is waiting for its partner. A lock flag rises after a programmable run of clean reference periods and drops as soon as one period carries too much pending phase error. The proportional kick is applied only in edge mode. In exclusive-OR mode the integral word alone steers the oscillator, so an idle loop does not bias itself.

Top module: `dpll_core`

## Requirements
- R1: During and right after reset, osc_out=0, fb_out=0, locked=0, phase_ok=1, and demod equals inc_min + (inc_max - inc_min)/2 (integer division).
- R2: With pd_sel=0 (exclusive-OR detector) and sig_in held low, demod stays within 8 of the window centre, and the oscillator keeps running at the period that centre word gives (2^ACC_W / demod cycles).
- R3: With pd_sel=1 (edge detector), a pending feedback edge never raises demod. With sig_in held low, demod settles at exactly inc_min and stays there.
- R4: With pd_sel=1, a pending reference edge never lowers demod. A reference far faster than the window allows drives demod to within 4 of inc_max.
- R5: demod never leaves the window [inc_min, inc_max] set on the previous cycle.
- R6: While inhibit=1, osc_out, fb_out and demod hold their values. After inhibit returns to 0, osc_out toggles again within one oscillator period.
- R7: fb_out produces one rising edge per div_n rising edges of osc_out (div_n of 0 or 1 passes the oscillator straight through). In edge mode the loop then locks with the oscillator at div_n times the reference frequency.
- R8: With a constant increment, osc_out is high for half of each period (within one cycle), and so is fb_out when div_n is 1.
- R9: In edge mode with a reference inside the window, locked rises after lock_need clean reference periods, and demod settles on the matching increment. A period is clean when phase_ok is low for at most LOCK_TOL cycles. Once that count is exceeded, locked is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Reference signal (asynchronous, synchronised internally) |
| pd_sel | input | 1 | Detector select: 0 exclusive-OR, 1 rising-edge phase/frequency |
| inhibit | input | 1 | 1 freezes oscillator, divider and loop filter |
| inc_min | input | ACC_W | Lowest oscillator increment |
| inc_max | input | ACC_W | Highest oscillator increment |
| div_n | input | DIV_W | Feedback divide ratio |
| lock_need | input | LOCK_W | Clean reference periods required for lock |
| osc_out | output | 1 | Oscillator square wave |
| fb_out | output | 1 | Divided feedback square wave |
| demod | output | ACC_W | Integral control word (demodulated output) |
| phase_ok | output | 1 | High when no detector edge is pending |
| locked | output | 1 | Lock indication |

## Verification
A corrupted integral word shows at demod on the very next cycle. Within one oscillator period it also moves the spacing of osc_out edges, so window-bound and direction checks on demod catch it quickly. A wrong divider count or a wrong detector state shows only over many reference periods: as a drifting ratio of feedback edges to oscillator edges, as demod parking away from its expected floor, ceiling or tracking value, or as locked failing to rise or fall. The bench therefore runs tens of thousands of cycles per scenario before it compares.

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int ACC_W    = 16,
  parameter int FRAC     = 4,
  parameter int KP_SH    = 8,
  parameter int DIV_W    = 8,
  parameter int LOCK_W   = 8,
  parameter int LOCK_TOL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              pd_sel,
  input  logic              inhibit,
  input  logic [ACC_W-1:0]  inc_min,
  input  logic [ACC_W-1:0]  inc_max,
  input  logic [DIV_W-1:0]  div_n,
  input  logic [LOCK_W-1:0] lock_need,
  output logic              osc_out,
  output logic              fb_out,
  output logic [ACC_W-1:0]  demod,
  output logic              phase_ok,
  output logic              locked
);
  localparam int IW = ACC_W + FRAC;
  localparam int SW = IW + 2;

  logic              sig_m, sig_s, sig_d;
  logic [ACC_W-1:0]  acc;
  logic              osc_d, fb_d;
  logic [DIV_W-1:0]  div_cnt;
  logic              up, dn;
  logic [IW-1:0]     integ;
  logic [LOCK_W-1:0] miss, run;

  wire sig_rise = sig_s & ~sig_d;
  wire fb_rise  = fb_out & ~fb_d;
  wire osc_edge = osc_out ^ osc_d;
  wire up_set   = up | sig_rise;
  wire dn_set   = dn | fb_rise;

  assign osc_out  = acc[ACC_W-1];
  assign demod    = integ[IW-1:FRAC];
  assign phase_ok = ~(up | dn);

  wire [ACC_W-1:0] centre   = inc_min + ((inc_max - inc_min) >> 1);
  wire [DIV_W-1:0] div_last = (div_n == '0) ? '0 : div_n - DIV_W'(1);
  wire [LOCK_W:0]  run_inc  = {1'b0, run} + (LOCK_W+1)'(1);

  logic signed [1:0] err;
  always_comb begin
    if (!pd_sel)  err = (sig_s ^ fb_out) ? 2'sd1 : -2'sd1;
    else if (up)  err = 2'sd1;
    else if (dn)  err = -2'sd1;
    else          err = 2'sd0;
  end

  logic signed [SW-1:0] i_sum, i_lo, i_hi, p_sum, p_kick, p_lo, p_hi;
  logic [IW-1:0]        integ_nx;
  logic [ACC_W-1:0]     inc;
  always_comb begin
    i_lo  = SW'(inc_min) <<< FRAC;
    i_hi  = SW'(inc_max) <<< FRAC;
    i_sum = $signed({2'b00, integ}) + SW'(err);
    if (i_sum < i_lo)      integ_nx = i_lo[IW-1:0];
    else if (i_sum > i_hi) integ_nx = i_hi[IW-1:0];
    else                   integ_nx = i_sum[IW-1:0];

    p_kick = '0;
    if (pd_sel) p_kick = SW'(err) <<< KP_SH;
    p_lo  = $signed(SW'(inc_min));
    p_hi  = $signed(SW'(inc_max));
    p_sum = $signed(SW'(demod)) + p_kick;
    if (p_sum < p_lo)      inc = inc_min;
    else if (p_sum > p_hi) inc = inc_max;
    else                   inc = p_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_m   <= 1'b0;
      sig_s   <= 1'b0;
      sig_d   <= 1'b0;
      acc     <= '0;
      osc_d   <= 1'b0;
      fb_out  <= 1'b0;
      fb_d    <= 1'b0;
      div_cnt <= '0;
      up      <= 1'b0;
      dn      <= 1'b0;
      integ   <= IW'(centre) << FRAC;
      miss    <= '0;
      run     <= '0;
      locked  <= 1'b0;
    end else begin
      sig_m <= sig_in;
      sig_s <= sig_m;
      sig_d <= sig_s;
      fb_d  <= fb_out;

      if (up_set & dn_set) begin
        up <= 1'b0;
        dn <= 1'b0;
      end else begin
        up <= up_set;
        dn <= dn_set;
      end

      if (!inhibit) begin
        acc   <= acc + inc;
        osc_d <= osc_out;
        integ <= integ_nx;
        if (osc_edge) begin
          if (div_cnt >= div_last) begin
            div_cnt <= '0;
            fb_out  <= ~fb_out;
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
      end

      if (sig_rise)                   miss <= '0;
      else if (!phase_ok && miss != '1) miss <= miss + LOCK_W'(1);

      if (miss > LOCK_W'(LOCK_TOL)) begin
        run    <= '0;
        locked <= 1'b0;
      end else if (sig_rise) begin
        if (run != '1) run <= run + LOCK_W'(1);
        if (run_inc >= {1'b0, lock_need}) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int ACC_W    = 16,
  parameter int LOCK_W   = 8,
  parameter int LOCK_TOL = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inhibit,
  input logic              pd_sel,
  input logic [ACC_W-1:0]  inc_min,
  input logic [ACC_W-1:0]  inc_max,
  input logic [ACC_W-1:0]  demod,
  input logic              osc_out,
  input logic              fb_out,
  input logic              up,
  input logic              dn,
  input logic              locked,
  input logic [LOCK_W-1:0] miss
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  AST_DEMOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (demod >= $past(inc_min) && demod <= $past(inc_max))); // R5
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> ($stable(osc_out) && $stable(fb_out) && $stable(demod))); // R6
  AST_DN_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_sel && dn && !inhibit) |=> demod <= $past(demod)); // R3
  AST_UP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_sel && up && !inhibit) |=> demod >= $past(demod)); // R4
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss > LOCK_W'(LOCK_TOL)) |=> !locked); // R9
endmodule

bind dpll_core dpll_core_chk #(.ACC_W(ACC_W), .LOCK_W(LOCK_W), .LOCK_TOL(LOCK_TOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .pd_sel(pd_sel),
  .inc_min(inc_min), .inc_max(inc_max), .demod(demod),
  .osc_out(osc_out), .fb_out(fb_out), .up(up), .dn(dn),
  .locked(locked), .miss(miss)
);

// File: tb/dpll_core_test.sv
module dpll_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic        pd_sel = 1'b0;
  logic        inhibit = 1'b0;
  logic [15:0] inc_min = 16'd512;
  logic [15:0] inc_max = 16'd3072;
  logic [7:0]  div_n = 8'd1;
  logic [7:0]  lock_need = 8'd16;
  logic        osc_out, fb_out, phase_ok, locked;
  logic [15:0] demod;

  int checks = 0;
  int errors = 0;
  int sig_half = 0;
  int sig_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpll_core uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .pd_sel(pd_sel), .inhibit(inhibit),
    .inc_min(inc_min), .inc_max(inc_max), .div_n(div_n), .lock_need(lock_need),
    .osc_out(osc_out), .fb_out(fb_out), .demod(demod), .phase_ok(phase_ok), .locked(locked)
  );

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sig_half == 0) begin
        sig_in  = 1'b0;
        sig_cnt = 0;
      end else begin
        sig_cnt++;
        if (sig_cnt >= sig_half) begin
          sig_cnt = 0;
          sig_in  = ~sig_in;
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic do_reset(input bit mode, input int nd, input int need, input int half);
    pd_sel    = mode;
    div_n     = 8'(nd);
    lock_need = 8'(need);
    sig_half  = half;
    inhibit   = 1'b0;
    rst_n     = 1'b0;
    tick(4);
    rst_n     = 1'b1;
  endtask

  task automatic test_reset;
    do_reset(1'b1, 1, 16, 0);
    chk(osc_out == 1'b0 && fb_out == 1'b0, "R1",
        $sformatf("osc=%0b fb=%0b expected 0 0", osc_out, fb_out));
    chk(locked == 1'b0 && phase_ok == 1'b1, "R1",
        $sformatf("locked=%0b phase_ok=%0b expected 0 1", locked, phase_ok));
    chk(demod == 16'd1792, "R1", $sformatf("demod=%0d expected 1792", demod));
  endtask

  task automatic test_xor_idle;
    int dev_max = 0;
    int rises = 0;
    logic prev;
    do_reset(1'b0, 1, 16, 0);
    tick(200);
    prev = osc_out;
    for (int i = 0; i < 4000; i++) begin
      int d;
      tick(1);
      d = int'(demod) - 1792;
      if (d < 0) d = -d;
      if (d > dev_max) dev_max = d;
      if (osc_out && !prev) rises++;
      prev = osc_out;
    end
    chk(dev_max <= 8, "R2", $sformatf("max deviation=%0d expected <=8", dev_max));
    chk(rises >= 100 && rises <= 120, "R2",
        $sformatf("osc rises=%0d expected 100..120", rises));
  endtask

  task automatic test_divider;
    int o_r = 0;
    int f_r = 0;
    int diff;
    logic po, pf;
    do_reset(1'b0, 3, 16, 0);
    tick(200);
    po = osc_out;
    pf = fb_out;
    for (int i = 0; i < 3600; i++) begin
      tick(1);
      if (osc_out && !po) o_r++;
      if (fb_out && !pf) f_r++;
      po = osc_out;
      pf = fb_out;
    end
    diff = o_r - 3 * f_r;
    if (diff < 0) diff = -diff;
    chk(diff <= 3 && f_r > 20, "R7",
        $sformatf("osc rises=%0d fb rises=%0d expected ratio 3", o_r, f_r));
  endtask

  task automatic test_edge_idle;
    int bad = 0;
    int o_hi = 0;
    int f_hi = 0;
    do_reset(1'b1, 1, 16, 0);
    tick(25000);
    chk(demod == 16'd512, "R3", $sformatf("demod=%0d expected 512", demod));
    for (int i = 0; i < 500; i++) begin
      tick(1);
      if (demod != 16'd512) bad++;
    end
    chk(bad == 0, "R3", $sformatf("cycles off floor=%0d expected 0", bad));
    for (int i = 0; i < 1280; i++) begin
      tick(1);
      if (osc_out) o_hi++;
      if (fb_out) f_hi++;
    end
    chk(o_hi >= 639 && o_hi <= 641, "R8", $sformatf("osc high=%0d expected 640", o_hi));
    chk(f_hi >= 639 && f_hi <= 641, "R8", $sformatf("fb high=%0d expected 640", f_hi));
  endtask

  task automatic test_edge_fast;
    int lo = 65535;
    int hi = 0;
    do_reset(1'b1, 8, 16, 2);
    tick(30000);
    for (int i = 0; i < 500; i++) begin
      tick(1);
      if (int'(demod) < lo) lo = int'(demod);
      if (int'(demod) > hi) hi = int'(demod);
    end
    chk(lo >= 3068 && hi <= 3072, "R4",
        $sformatf("demod range %0d..%0d expected 3068..3072", lo, hi));
  endtask

  task automatic test_inhibit;
    logic so, sf;
    logic [15:0] sd;
    int moved = 0;
    int toggles = 0;
    logic prev;
    do_reset(1'b0, 1, 16, 0);
    tick(300);
    inhibit = 1'b1;
    so = osc_out;
    sf = fb_out;
    sd = demod;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      if (osc_out != so || fb_out != sf || demod != sd) moved++;
    end
    chk(moved == 0, "R6", $sformatf("cycles changed while inhibited=%0d expected 0", moved));
    inhibit = 1'b0;
    prev = osc_out;
    for (int i = 0; i < 100; i++) begin
      tick(1);
      if (osc_out != prev) toggles++;
      prev = osc_out;
    end
    chk(toggles >= 2, "R6", $sformatf("toggles after release=%0d expected >=2", toggles));
  endtask

  task automatic test_lock;
    do_reset(1'b1, 1, 16, 16);
    tick(30000);
    chk(locked == 1'b1, "R9", $sformatf("locked=%0b expected 1", locked));
    chk(demod >= 16'd2045 && demod <= 16'd2051, "R9",
        $sformatf("demod=%0d expected 2048+-3", demod));
    sig_half = 0;
    tick(100);
    chk(locked == 1'b0, "R9", $sformatf("locked after loss=%0b expected 0", locked));
  endtask

  task automatic test_synth;
    do_reset(1'b1, 4, 16, 64);
    tick(40000);
    chk(locked == 1'b1, "R7", $sformatf("locked=%0b expected 1", locked));
    chk(demod >= 16'd2045 && demod <= 16'd2051, "R7",
        $sformatf("demod=%0d expected 2048+-3", demod));
  endtask

  initial begin
    test_reset;
    test_xor_idle;
    test_divider;
    test_edge_idle;
    test_edge_fast;
    test_inhibit;
    test_lock;
    test_synth;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: ran 190000 cycles, expected completion earlier");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule